// File: doc/BRIEF.md
# Fast Interrupt Vector Generator

This block watches 128 fast-interrupt request lines. They arrive as four 32-bit source words, each with a matching enable word. Every clock it picks the highest-priority source that is both requesting and enabled. It then registers a 32-bit service address for that source, computed as a programmable base plus a programmable per-source stride multiplied by the source index. When no source is active, the registered value is all ones, and a separate valid flag makes that case plain.

Software reads the registered vector through a read-only data port qualified by a read strobe. After a handler clears the request it has serviced, the next read returns the vector of the next lower-priority active source. Repeated reads therefore walk down the pending sources until the all-ones value appears. The port has no write path, so the vector can only change through the request, enable and configuration inputs.

Top module: `fastirq_vector_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the registered vector becomes 32'h0000_0000 and `vec_valid_o` becomes 0.
- R2: Source index n is carried on bit n of the 128-bit request and enable buses. Bit n lies in source word n/32 at bit position n%32, so source 0 is word 0 bit 0 and source 127 is word 3 bit 31.
- R3: A source counts as active only when its request bit and its enable bit are both 1. A request with a cleared enable bit has no effect on the vector.
- R4: Among active sources, the one with the lowest index wins.
- R5: The vector for winning source n is `base_i + stride_i * n`, truncated to 32 bits. Any carry out of bit 31 is dropped.
- R6: When no source is active, the registered vector is 32'hFFFF_FFFF and `vec_valid_o` is 0.
- R7: `vec_valid_o` is 1 whenever at least one source was active at the previous clock edge.
- R8: The vector and the valid flag change exactly one rising clock edge after the request, enable, base or stride inputs change, and stay unchanged while those inputs stay unchanged.
- R9: `rd_data_o` equals the registered vector while `rd_en_i` is 1 and is 32'h0 while it is 0.
- R10: When higher-priority active sources are cleared one at a time, successive reads return the vectors of the remaining active sources in increasing index order, then 32'hFFFF_FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req_i | input | 128 | Request lines; bit n is source n |
| src_en_i | input | 128 | Enable mask; bit n is source n |
| base_i | input | 32 | Vector base address |
| stride_i | input | 32 | Per-source vector stride |
| rd_en_i | input | 1 | Read strobe for the vector register |
| rd_data_o | output | 32 | Read data: the registered vector when strobed, else zero |
| vec_valid_o | output | 1 | At least one source is active |

## Verification
The vector and valid flag are due exactly one rising edge after any change to requests, enables, base or stride. Read data follows the strobe within the same cycle, with no extra register. The bench changes inputs just after a falling edge and compares at the next falling edge, so exactly one rising edge lies between stimulus and check. For latency it also samples once before that rising edge to confirm the old value still holds. A behavioural model advanced on the same rising edge is compared at every falling edge. Directed checks against hand-computed constants cover priority, masking, wrap-around and the walk-down sequence.

// File: rtl/fv_pkg.sv
// Package fv_pkg
// Shared sizing for the fast-interrupt vector generator.
// Assumes the vector and configuration values share one width.
package fv_pkg;
    localparam int unsigned FV_VEC_W     = 32;
    localparam logic [FV_VEC_W-1:0] FV_NONE_VEC = '1;
    localparam logic [FV_VEC_W-1:0] FV_RST_VEC  = '0;
    typedef logic [FV_VEC_W-1:0] fv_vec_t;
endpackage

// File: rtl/fv_word_scan.sv
// Module fv_word_scan
// Finds the lowest set bit of one source word and flags whether any bit is set.
// Assumes WORD_W is at least 2.
module fv_word_scan #(
    parameter int unsigned WORD_W = 32,
    localparam int unsigned BIT_W = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] act_i,
    output logic              hit_o,
    output logic [BIT_W-1:0]  pos_o
);
    // Scan from the top down so the lowest set bit is the last one written.
    always_comb begin
        hit_o = |act_i;
        pos_o = '0;
        for (int b = WORD_W - 1; b >= 0; b--) begin
            if (act_i[b]) pos_o = BIT_W'(b);
        end
    end
endmodule

// File: rtl/fv_prio_sel.sv
// Module fv_prio_sel
// Selects the lowest-index active source across all source words.
// Assumes word w holds sources w*WORD_W .. w*WORD_W+WORD_W-1.
module fv_prio_sel #(
    parameter int unsigned NUM_WORDS = 4,
    parameter int unsigned WORD_W    = 32,
    localparam int unsigned NUM_SRC  = NUM_WORDS * WORD_W,
    localparam int unsigned IDX_W    = $clog2(NUM_SRC),
    localparam int unsigned BIT_W    = $clog2(WORD_W)
) (
    input  logic [NUM_SRC-1:0] act_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o
);
    logic [NUM_WORDS-1:0] hit;
    logic [BIT_W-1:0]     pos [NUM_WORDS];

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        fv_word_scan #(.WORD_W(WORD_W)) u_scan (
            .act_i (act_i[w*WORD_W +: WORD_W]),
            .hit_o (hit[w]),
            .pos_o (pos[w])
        );
    end

    // Pick the lowest word with a hit and join word and bit into one index.
    always_comb begin
        any_o = |hit;
        idx_o = '0;
        for (int w = NUM_WORDS - 1; w >= 0; w--) begin
            if (hit[w]) idx_o = IDX_W'(w * WORD_W) + IDX_W'(pos[w]);
        end
    end
endmodule

// File: rtl/fv_vec_calc.sv
// Module fv_vec_calc
// Forms base + stride * index, truncated to the vector width, or all ones when idle.
// Assumes the index is narrower than the vector width.
module fv_vec_calc
    import fv_pkg::*;
#(
    parameter int unsigned IDX_W = 7
) (
    input  logic             any_i,
    input  logic [IDX_W-1:0] idx_i,
    input  fv_vec_t          base_i,
    input  fv_vec_t          stride_i,
    output fv_vec_t          vec_o
);
    fv_vec_t offset;

    // Multiply in the vector width so the carry beyond it is dropped.
    always_comb begin
        offset = stride_i * FV_VEC_W'(idx_i);
        vec_o  = any_i ? (base_i + offset) : FV_NONE_VEC;
    end
endmodule

// File: rtl/fastirq_vector_unit.sv
// Module fastirq_vector_unit
// Top level: masks requests, selects the winning source, registers its vector
// and presents it on a read-only port qualified by a read strobe.
// Assumes all inputs are synchronous to clk.
module fastirq_vector_unit
    import fv_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 4,
    parameter int unsigned WORD_W    = 32,
    localparam int unsigned NUM_SRC  = NUM_WORDS * WORD_W,
    localparam int unsigned IDX_W    = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req_i,
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic [31:0]        base_i,
    input  logic [31:0]        stride_i,
    input  logic               rd_en_i,
    output logic [31:0]        rd_data_o,
    output logic               vec_valid_o
);
    logic [NUM_SRC-1:0] act;
    logic               any_act;
    logic [IDX_W-1:0]   win_idx;
    fv_vec_t            vec_nxt;
    fv_vec_t            vec_q;
    logic               vld_q;

    // Qualify each request with its enable bit.
    always_comb act = src_req_i & src_en_i;

    fv_prio_sel #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_sel (
        .act_i (act),
        .any_o (any_act),
        .idx_o (win_idx)
    );

    fv_vec_calc #(.IDX_W(IDX_W)) u_calc (
        .any_i    (any_act),
        .idx_i    (win_idx),
        .base_i   (base_i),
        .stride_i (stride_i),
        .vec_o    (vec_nxt)
    );

    // Register the vector and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= FV_RST_VEC;
            vld_q <= 1'b0;
        end else begin
            vec_q <= vec_nxt;
            vld_q <= any_act;
        end
    end

    // Drive the read port only while strobed.
    always_comb begin
        rd_data_o   = rd_en_i ? vec_q : '0;
        vec_valid_o = vld_q;
    end
endmodule

// File: rtl/fastirq_vector_unit_chk.sv
// Module fastirq_vector_unit_chk
// Assertion checker for fastirq_vector_unit, attached by bind.
module fastirq_vector_unit_chk #(
    parameter int unsigned NUM_SRC = 128
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_req_i,
    input logic [NUM_SRC-1:0] src_en_i,
    input logic [31:0]        base_i,
    input logic [31:0]        stride_i,
    input logic               rd_en_i,
    input logic [31:0]        rd_data_o,
    input logic               vec_valid_o,
    input logic [31:0]        vec_q
);
    // R7
    valid_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (vec_valid_o == (|$past(src_req_i & src_en_i))));

    // R6
    idle_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !vec_valid_o) |-> (vec_q == 32'hFFFF_FFFF));

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(src_req_i) && $stable(src_en_i)
         && $stable(base_i) && $stable(stride_i)) |=> $stable(vec_q));

    // R9
    rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |-> (rd_data_o == 32'h0));

    // R9
    rd_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |-> (rd_data_o == vec_q));
endmodule

bind fastirq_vector_unit fastirq_vector_unit_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_req_i   (src_req_i),
    .src_en_i    (src_en_i),
    .base_i      (base_i),
    .stride_i    (stride_i),
    .rd_en_i     (rd_en_i),
    .rd_data_o   (rd_data_o),
    .vec_valid_o (vec_valid_o),
    .vec_q       (vec_q)
);

// File: tb/fastirq_vector_unit_tb.sv
`timescale 1ns/1ps
module fastirq_vector_unit_tb;
    logic         clk = 1'b0;
    logic         rst_n;
    logic [127:0] req, en;
    logic [31:0]  base, stride;
    logic         rd_en;
    logic [31:0]  rd_data;
    logic         vld;

    int tests = 0;
    int fails = 0;
    bit done  = 0;
    string phase = "R1";

    logic [31:0] m_vec;
    logic        m_vld;

    always #2.5 clk = ~clk;

    fastirq_vector_unit u_dut (
        .clk(clk), .rst_n(rst_n), .src_req_i(req), .src_en_i(en),
        .base_i(base), .stride_i(stride), .rd_en_i(rd_en),
        .rd_data_o(rd_data), .vec_valid_o(vld)
    );

    // Behavioural reference: first enabled request from index 0 upward.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_vec = 32'h0;
            m_vld = 1'b0;
        end else begin
            m_vec = 32'hFFFF_FFFF;
            m_vld = 1'b0;
            for (int n = 127; n >= 0; n--) begin
                if (req[n] && en[n]) begin
                    m_vec = base + stride * n;
                    m_vld = 1'b1;
                end
            end
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, clear of both clock edges.
    always @(negedge clk) begin
        #1;
        if (!done) begin
            check({phase, " model-vec"}, rd_data, rd_en ? m_vec : 32'h0);
            check({phase, " model-vld"}, {31'b0, vld}, {31'b0, m_vld});
        end
    end

    // Wait one rising edge and land just after the next falling edge.
    task automatic settle();
        @(negedge clk);
        #1.2;
    endtask

    task automatic expect_vec(string tag, logic [31:0] exp, logic expv);
        settle();
        check(tag, rd_data, exp);
        check({tag, " valid"}, {31'b0, vld}, {31'b0, expv});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got timeout expected completion");
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req = '0; en = '1; base = 32'h1000; stride = 32'h40; rd_en = 1'b1;
        req[3] = 1'b1;
        repeat (3) settle();
        // R1: reset value despite an active request
        check("R1 reset vec", rd_data, 32'h0);
        check("R1 reset vld", {31'b0, vld}, 32'h0);
        rst_n = 1'b1;
        phase = "R5";
        expect_vec("R5 src3", 32'h10C0, 1'b1);

        // R2: bit 37 lies in word 1, bit 5
        phase = "R2";
        req = '0; req[37] = 1'b1;
        expect_vec("R2 src37", 32'h1940, 1'b1);
        req = '0; req[127] = 1'b1;
        expect_vec("R2 src127", 32'h1000 + 32'h40 * 127, 1'b1);

        // R3: masked low request does not win
        phase = "R3";
        req = '0; req[2] = 1'b1; req[9] = 1'b1; en = '1; en[2] = 1'b0;
        expect_vec("R3 masked", 32'h1240, 1'b1);
        req = '0; req[50] = 1'b1; en = '0;
        expect_vec("R3 all masked", 32'hFFFF_FFFF, 1'b0);
        en = '1;

        // R4: lowest index wins across words
        phase = "R4";
        req = '0; req[100] = 1'b1; req[33] = 1'b1; req[64] = 1'b1;
        expect_vec("R4 prio", 32'h1000 + 32'h40 * 33, 1'b1);

        // R5: wrap past 32 bits
        phase = "R5";
        base = 32'hFFFF_FF00; stride = 32'h100; req = '0; req[3] = 1'b1;
        expect_vec("R5 wrap", 32'h0000_0200, 1'b1);

        // R8: old value holds before the edge, new one after
        phase = "R8";
        base = 32'h2000; stride = 32'h8; req = '0; req[1] = 1'b1;
        settle();
        req = '0; req[4] = 1'b1;
        #0.5;
        check("R8 before edge", rd_data, 32'h2008);
        expect_vec("R8 after edge", 32'h2020, 1'b1);

        // R9: read strobe gates the data port
        phase = "R9";
        rd_en = 1'b0;
        #0.2;
        check("R9 no strobe", rd_data, 32'h0);
        settle();
        check("R9 no strobe held", rd_data, 32'h0);
        rd_en = 1'b1;

        // R10: walk down while clearing serviced sources
        phase = "R10";
        base = 32'h8000; stride = 32'h10;
        req = '0; req[5] = 1'b1; req[40] = 1'b1; req[127] = 1'b1;
        expect_vec("R10 first", 32'h8050, 1'b1);
        req[5] = 1'b0;
        expect_vec("R10 second", 32'h8280, 1'b1);
        req[40] = 1'b0;
        expect_vec("R10 third", 32'h87F0, 1'b1);
        req[127] = 1'b0;
        // R6: idle value
        expect_vec("R6 R10 none", 32'hFFFF_FFFF, 1'b0);

        // R4 R5 R7: random traffic against the model
        phase = "R7";
        for (int i = 0; i < 400; i++) begin
            req = {$urandom, $urandom, $urandom, $urandom};
            en  = {$urandom, $urandom, $urandom, $urandom};
            if (i % 3 == 0) req = req & {4{32'h0000_0101 << (i % 20)}};
            if (i % 7 == 0) en = '0;
            base = $urandom; stride = $urandom;
            rd_en = (i % 5 != 0);
            settle();
        end

        // R1: reset mid-run
        phase = "R1";
        rst_n = 1'b0;
        settle();
        rd_en = 1'b1;
        #0.2;
        check("R1 mid reset", rd_data, 32'h0);
        rst_n = 1'b1;
        settle();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule